// File: doc/BRIEF.md
# Multidrop Nine-Bit Address Filter

This block sits between a serial receiver and its receive FIFO on a line shared by several listeners. In nine-bit operation, every received character carries eight data bits. It also carries a ninth qualifier bit in the slot a parity bit would otherwise take. A character with the qualifier set is an address. A character with it clear is data. The filter compares each address character with a programmed station address. Only the bit positions selected by a mask take part in the comparison. The filter then decides whether the data characters that follow reach the FIFO.

On a match, the address character itself is written to the FIFO, so software can see which address selected this station. A one-cycle match interrupt fires at the same time, and data characters are accepted until the next address arrives. On a mismatch, the address and every following data character are dropped. When nine-bit operation is off, every character goes straight through. No parity check is done on the qualifier bit.

The transmit side tags each outgoing character as it is handed to the serializer. The transmit FIFO keeps no ninth bit, so this choice is made per character.

The receive controller has two states. `ST_DROP` is the reset state and discards data. `ST_ACCEPT` writes data to the FIFO. The named transitions are:
- `T_HIT`: an address matches; the next state is `ST_ACCEPT`.
- `T_MISS`: an address does not match; the next state is `ST_DROP`.
- `T_BYPASS`: nine-bit operation is off; the state is forced to `ST_DROP`.

Data characters cause no transition.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, `fifo_wr_en` and `match_irq` are low and the filter is in `ST_DROP`, so data characters (qualifier 0) received before any address are not written.
- R2: With `mode9_en` low, every character with `rx_valid` high is written: `fifo_wr_en` is high in the following cycle with `fifo_wr_data` equal to `rx_data`, whatever `rx_bit9` is, and `match_irq` stays low.
- R3: With `mode9_en` high, a character with `rx_bit9`=1 matches when `((rx_data ^ own_addr) & addr_mask) == 0`. A mask bit of 0 makes that bit position a don't-care.
- R4: With `addr_mask` = 8'hFF, only the exact value `own_addr` matches; a value differing in any single bit does not.
- R5: On a match, the cycle after `rx_valid` has `fifo_wr_en` high with the address byte on `fifo_wr_data`, and `match_irq` high for that one cycle.
- R6: In `ST_ACCEPT`, each character with `rx_bit9`=0 is written to the FIFO in the following cycle, unchanged, with no interrupt.
- R7: On a mismatch, the address byte is not written, no interrupt fires, and all following characters with `rx_bit9`=0 are dropped.
- R8: The matched or unmatched state holds across any number of data characters and changes only on the next address character. A non-matching address received while in `ST_ACCEPT` returns the filter to `ST_DROP`.
- R9: Clearing `mode9_en` returns the filter to `ST_DROP`. After nine-bit mode is enabled again, data is dropped until a matching address arrives.
- R10: Each transmit character appears on `tx_out_data` with `tx_out_valid` one cycle after `tx_in_valid`. `tx_out_bit9` is 1 only when `mode9_en`, `tx_sticky_par` and `tx_odd_par` are all high for that character; in every other case it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode9_en | input | 1 | Nine-bit multidrop mode enable |
| own_addr | input | 8 | Programmed station address |
| addr_mask | input | 8 | Compare mask (1 = bit takes part) |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Received qualifier bit (1 = address) |
| fifo_wr_en | output | 1 | Receive FIFO write strobe |
| fifo_wr_data | output | 8 | Receive FIFO write data |
| match_irq | output | 1 | One-cycle address match pulse |
| tx_in_valid | input | 1 | Transmit character strobe from FIFO |
| tx_in_data | input | 8 | Transmit character data |
| tx_sticky_par | input | 1 | Sticky parity selected for this character |
| tx_odd_par | input | 1 | Odd parity selected for this character |
| tx_out_valid | output | 1 | Character strobe to serializer |
| tx_out_data | output | 8 | Character data to serializer |
| tx_out_bit9 | output | 1 | Ninth bit to serializer (1 = address) |

## Verification
The bench sends an address that differs from `own_addr` in a single bit, once under a full mask and once with that bit masked off. A design that ignores the mask, or inverts it, gets one of the two cases wrong. It checks that data is dropped right after reset and again after nine-bit mode is toggled off and on. A filter that resets into, or keeps, the accepting state would leak data into the FIFO. It sends a mismatching address while the filter is accepting and then sends data. A filter that latches a match forever would go on writing. On the transmit side, it walks through all four combinations of sticky and odd selection, with the mode on and off. A tag that ignores one qualifier would mark data characters as addresses.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    typedef enum logic [0:0] {
        ST_DROP   = 1'b0,
        ST_ACCEPT = 1'b1
    } mdf_state_e;
endpackage

// File: rtl/mdf_addr_cmp.sv
module mdf_addr_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] cand,
    input  logic [W-1:0] ref_addr,
    input  logic [W-1:0] mask,
    output logic         hit
);
    logic [W-1:0] diff;
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = (cand[i] ^ ref_addr[i]) & mask[i];
    end
    assign hit = (diff == '0);
endmodule

// File: rtl/mdf_rx_fsm.sv
module mdf_rx_fsm
    import mdf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode9_en,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_bit9,
    input  logic         addr_hit,
    output logic         wr_en,
    output logic [W-1:0] wr_data,
    output logic         irq
);
    mdf_state_e st, nxt;
    logic       wr_c, irq_c;

    // next state and output decisions
    always_comb begin
        nxt   = st;
        wr_c  = 1'b0;
        irq_c = 1'b0;
        if (!mode9_en) begin
            nxt  = ST_DROP;          // T_BYPASS
            wr_c = rx_valid;
        end else if (rx_valid) begin
            if (rx_bit9) begin
                if (addr_hit) begin
                    nxt   = ST_ACCEPT;  // T_HIT
                    wr_c  = 1'b1;
                    irq_c = 1'b1;
                end else begin
                    nxt   = ST_DROP;    // T_MISS
                end
            end else begin
                unique case (st)
                    ST_DROP:   wr_c = 1'b0;
                    ST_ACCEPT: wr_c = 1'b1;
                    default:   wr_c = 1'b0;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_DROP;
        else        st <= nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
            irq     <= 1'b0;
        end else begin
            wr_en   <= wr_c;
            irq     <= irq_c;
            if (wr_c) wr_data <= rx_data;
        end
    end
endmodule

// File: rtl/mdf_tx_tag.sv
module mdf_tx_tag #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode9_en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         sticky,
    input  logic         odd,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_bit9
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_bit9  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
                out_bit9 <= mode9_en & sticky & odd;
            end
        end
    end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode9_en,
    input  logic [W-1:0] own_addr,
    input  logic [W-1:0] addr_mask,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         rx_bit9,
    output logic         fifo_wr_en,
    output logic [W-1:0] fifo_wr_data,
    output logic         match_irq,
    input  logic         tx_in_valid,
    input  logic [W-1:0] tx_in_data,
    input  logic         tx_sticky_par,
    input  logic         tx_odd_par,
    output logic         tx_out_valid,
    output logic [W-1:0] tx_out_data,
    output logic         tx_out_bit9
);
    logic hit;

    mdf_addr_cmp #(.W(W)) u_cmp (
        .cand(rx_data), .ref_addr(own_addr), .mask(addr_mask), .hit(hit)
    );

    mdf_rx_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode9_en(mode9_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .addr_hit(hit), .wr_en(fifo_wr_en), .wr_data(fifo_wr_data),
        .irq(match_irq)
    );

    mdf_tx_tag #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode9_en(mode9_en),
        .in_valid(tx_in_valid), .in_data(tx_in_data),
        .sticky(tx_sticky_par), .odd(tx_odd_par),
        .out_valid(tx_out_valid), .out_data(tx_out_data), .out_bit9(tx_out_bit9)
    );
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode9_en,
    input logic [W-1:0] own_addr,
    input logic [W-1:0] addr_mask,
    input logic         rx_valid,
    input logic [W-1:0] rx_data,
    input logic         rx_bit9,
    input logic         fifo_wr_en,
    input logic [W-1:0] fifo_wr_data,
    input logic         match_irq,
    input logic         tx_in_valid,
    input logic         tx_sticky_par,
    input logic         tx_odd_par,
    input logic         tx_out_valid,
    input logic         tx_out_bit9
);
    // R5: every interrupt comes with the address byte being written
    assert_irq_with_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> fifo_wr_en);

    // R5: an interrupt only follows a received address character in nine-bit mode
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |-> $past(rx_valid && rx_bit9 && mode9_en));

    // R2: bypass writes every character unchanged, without interrupt
    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && !mode9_en) |->
            (fifo_wr_en && !match_irq && fifo_wr_data == $past(rx_data)));

    // R7: a mismatching address is never written
    assert_miss_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rx_valid && mode9_en && rx_bit9 &&
              (((rx_data ^ own_addr) & addr_mask) != '0)) |-> !fifo_wr_en);

    // R1: no write without a received character
    assert_no_spurious_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> $past(rx_valid));

    // R10: the ninth bit is only set under mode, sticky and odd selection
    assert_tx_bit9_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_out_valid && tx_out_bit9) |-> $past(mode9_en && tx_sticky_par && tx_odd_par));

    // R10: output strobe follows input strobe by one cycle
    assert_tx_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid |-> $past(tx_in_valid));
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode9_en(mode9_en), .own_addr(own_addr),
    .addr_mask(addr_mask), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .match_irq(match_irq), .tx_in_valid(tx_in_valid),
    .tx_sticky_par(tx_sticky_par), .tx_odd_par(tx_odd_par),
    .tx_out_valid(tx_out_valid), .tx_out_bit9(tx_out_bit9)
);

// File: tb/mdrop_addr_filter_test.sv
module mdrop_addr_filter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode9_en = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic [7:0] addr_mask = 8'hFF;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_bit9 = 1'b0;
    logic       fifo_wr_en;
    logic [7:0] fifo_wr_data;
    logic       match_irq;
    logic       tx_in_valid = 1'b0;
    logic [7:0] tx_in_data = 8'h00;
    logic       tx_sticky_par = 1'b0;
    logic       tx_odd_par = 1'b0;
    logic       tx_out_valid;
    logic [7:0] tx_out_data;
    logic       tx_out_bit9;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mdrop_addr_filter uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one character, then sample one cycle later at the negative edge
    task automatic rx_char(input logic [7:0] d, input logic b9,
                           input string req, input logic exp_wr, input logic exp_irq);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_bit9 = b9;
        @(negedge clk);
        rx_valid = 1'b0;
        check({req, " wr"}, fifo_wr_en, exp_wr);
        check({req, " irq"}, match_irq, exp_irq);
        if (exp_wr) check({req, " data"}, fifo_wr_data, d);
    endtask

    task automatic t_reset();
        check("R1 wr after reset", fifo_wr_en, 1'b0);
        check("R1 irq after reset", match_irq, 1'b0);
        mode9_en = 1'b1; own_addr = 8'h5A; addr_mask = 8'hFF;
        rx_char(8'h11, 1'b0, "R1 data before address", 1'b0, 1'b0);
    endtask

    task automatic t_passthrough();
        mode9_en = 1'b0;
        rx_char(8'hC3, 1'b0, "R2 bypass data", 1'b1, 1'b0);
        rx_char(8'h77, 1'b1, "R2 bypass qualifier set", 1'b1, 1'b0);
    endtask

    task automatic t_exact();
        mode9_en = 1'b1; own_addr = 8'h5A; addr_mask = 8'hFF;
        rx_char(8'h5B, 1'b1, "R4 one-bit-off address", 1'b0, 1'b0);
        rx_char(8'h22, 1'b0, "R7 data after miss", 1'b0, 1'b0);
        rx_char(8'h5A, 1'b1, "R5 exact address", 1'b1, 1'b1);
        rx_char(8'h33, 1'b0, "R6 data after hit", 1'b1, 1'b0);
        rx_char(8'h34, 1'b0, "R8 data persists", 1'b1, 1'b0);
    endtask

    task automatic t_masked();
        own_addr = 8'h5A; addr_mask = 8'hFE;
        rx_char(8'h5B, 1'b1, "R3 masked bit ignored", 1'b1, 1'b1);
        rx_char(8'h5D, 1'b1, "R3 unmasked bit differs", 1'b0, 1'b0);
        rx_char(8'h44, 1'b0, "R8 miss leaves accept", 1'b0, 1'b0);
        addr_mask = 8'h0F;
        rx_char(8'hAA, 1'b1, "R3 upper nibble masked", 1'b1, 1'b1);
    endtask

    task automatic t_disable();
        mode9_en = 1'b0;
        @(negedge clk);
        mode9_en = 1'b1;
        rx_char(8'h66, 1'b0, "R9 data after re-enable", 1'b0, 1'b0);
    endtask

    task automatic t_tx();
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            mode9_en = k[2]; tx_sticky_par = k[1]; tx_odd_par = k[0];
            tx_in_valid = 1'b1; tx_in_data = 8'h80 + 8'(k);
            @(negedge clk);
            tx_in_valid = 1'b0;
            check("R10 tx valid", tx_out_valid, 1'b1);
            check("R10 tx data", tx_out_data, 8'h80 + 8'(k));
            check("R10 tx bit9", tx_out_bit9, (k == 7) ? 1'b1 : 1'b0);
        end
        @(negedge clk);
        check("R10 tx idle", tx_out_valid, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthrough();
        t_exact();
        t_masked();
        t_disable();
        t_tx();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule